// File: doc/BRIEF.md
# Flash Erase Command Decoder

This block is the command interpreter of a parallel NOR flash device, limited to erase handling. Each host write arrives as a one-clock strobe with an address and a data byte, already synchronised to the clock at the point where the write-enable pulse rises. The decoder follows the five-write prefix that every erase shares. The sixth write chooses whole-chip erase or sector erase.

A sector erase opens an accept window of `WIN_CYC` clocks. Writing the sector-erase byte at another address inside the window adds that sector to an erase mask and starts the window again. When the window lapses, the embedded erase runs for `ERS_CYC` clocks and the mask is then cleared. The erase can be suspended, which takes `SUSP_CYC` clocks to settle, and resumed later. The host sees a ready flag, a bit showing that the window has closed, a two-bit mode and the per-sector mask.

Top module: `flash_erase_ctl`

## Requirements
- R1: The prefix is five writes. The unlock pair is address bits [10:0] = 555h with data AAh, then 2AAh with data 55h. The set-up write is 555h with data 80h, and then the unlock pair comes again. Any other write during the prefix drops the decoder back to idle: mode stays 0 (read) and the mask stays 0.
- R2: A sixth write of 10h at address 555h starts chip erase. From the clock after that write, for `ERS_CYC` clocks, the outputs are mode = 2 (erasing), ready = 0, timer-expired = 1 and the mask all ones. After that, mode is 0, ready is 1 and the mask is 0.
- R3: A sixth write of 30h sets the mask bit selected by address bits [SECT_W+10:11]. It also gives mode = 1 (pending), ready = 0 and timer-expired = 0.
- R4: If no write arrives, the window lasts exactly `WIN_CYC` clocks after the last accepted sector write. The decoder then shows mode = 2 and timer-expired = 1 for `ERS_CYC` clocks, then returns to mode 0 with the mask cleared.
- R5: A 30h write inside the window adds its sector to the mask and restarts the window count.
- R6: Any write inside the window other than 30h or B0h clears the mask and returns to mode 0 with ready = 1.
- R7: While chip erase runs, every write is ignored, including B0h and 30h.
- R8: A B0h write in the window or during sector erase holds mode = 2 and ready = 0 for `SUSP_CYC` clocks. After that, mode = 3 (suspended), ready = 1 and timer-expired = 1, with the mask kept.
- R9: While suspended, a 30h write resumes sector erase (mode 2), and the erase completes after its remaining clocks. Erase clocks spent before the suspend are counted. Any other write while suspended is ignored.
- R10: During sector erase, any write other than B0h is ignored.
- R11: An active-low reset, asynchronous, aborts any operation at once: mode 0, ready 1, timer-expired 0, mask 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrStb | input | 1 | One-clock pulse per host write |
| wrAddr | input | SECT_W+11 | Write address; top SECT_W bits select the sector |
| wrData | input | 8 | Write data byte |
| ready | output | 1 | 1 when no erase is running or pending |
| timerDone | output | 1 | 1 once the sector accept window has closed |
| mode | output | 2 | 0 read, 1 erase pending, 2 erasing, 3 suspended |
| eraseMask | output | 2**SECT_W | Sectors queued or being erased |

## Verification
Every write acts on the clock edge that samples its strobe, and all outputs come from registers, so a result appears right after that edge. Timed transitions occur a fixed number of edges after their cause: `WIN_CYC` after the last sector write, `SUSP_CYC` after B0h, and `ERS_CYC` after erase start, less the clocks already spent before a suspend. The bench counts edges from each write it issues. It samples on the falling edge one clock before each expected transition and again one clock after, which pins every duration to the exact clock.

// File: rtl/efc_pkg.sv
package efc_pkg;

  localparam logic [10:0] UNLK_ADDR_A = 11'h555;
  localparam logic [10:0] UNLK_ADDR_B = 11'h2AA;
  localparam logic [7:0]  UNLK_DATA_A = 8'hAA;
  localparam logic [7:0]  UNLK_DATA_B = 8'h55;
  localparam logic [7:0]  CMD_SETUP   = 8'h80;
  localparam logic [7:0]  CMD_CHIP    = 8'h10;
  localparam logic [7:0]  CMD_SECT    = 8'h30;
  localparam logic [7:0]  CMD_SUSP    = 8'hB0;

  typedef enum logic [1:0] {
    MODE_READ  = 2'd0,
    MODE_PEND  = 2'd1,
    MODE_ERASE = 2'd2,
    MODE_SUSP  = 2'd3
  } mode_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clrMask;
    logic addSect;
    logic setAll;
    logic winClr;
    logic winInc;
    logic ersClr;
    logic ersInc;
    logic suspClr;
    logic suspInc;
  } dpCtl_t;

  // decoded write and counter status from datapath to control
  typedef struct packed {
    logic unlkA;
    logic unlkB;
    logic setup;
    logic chipCmd;
    logic sectCmd;
    logic suspCmd;
    logic winDone;
    logic ersDone;
    logic suspDone;
  } dpStat_t;

endpackage

// File: rtl/efc_dp.sv
module efc_dp
  import efc_pkg::*;
#(
  parameter int SECT_W   = 3,
  parameter int WIN_CYC  = 16,
  parameter int ERS_CYC  = 40,
  parameter int SUSP_CYC = 6,
  localparam int ADDR_W  = SECT_W + 11,
  localparam int NUM_SECT = 1 << SECT_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   wrAddr,
  input  logic [7:0]          wrData,
  input  dpCtl_t              ctl,
  output dpStat_t             stat,
  output logic [NUM_SECT-1:0] eraseMask
);

  localparam int WIN_W  = $clog2(WIN_CYC + 1);
  localparam int ERS_W  = $clog2(ERS_CYC + 1);
  localparam int SUSP_W = $clog2(SUSP_CYC + 1);
  localparam logic [WIN_W-1:0]  WIN_LAST  = WIN_W'(WIN_CYC - 1);
  localparam logic [ERS_W-1:0]  ERS_LAST  = ERS_W'(ERS_CYC - 1);
  localparam logic [SUSP_W-1:0] SUSP_LAST = SUSP_W'(SUSP_CYC - 1);

  logic [WIN_W-1:0]  winCnt;
  logic [ERS_W-1:0]  ersCnt;
  logic [SUSP_W-1:0] suspCnt;
  logic [10:0]       lowAddr;
  logic [SECT_W-1:0] sectIdx;

  assign lowAddr = wrAddr[10:0];
  assign sectIdx = wrAddr[ADDR_W-1 -: SECT_W];

  always_comb begin
    stat.unlkA    = (lowAddr == UNLK_ADDR_A) && (wrData == UNLK_DATA_A);
    stat.unlkB    = (lowAddr == UNLK_ADDR_B) && (wrData == UNLK_DATA_B);
    stat.setup    = (lowAddr == UNLK_ADDR_A) && (wrData == CMD_SETUP);
    stat.chipCmd  = (lowAddr == UNLK_ADDR_A) && (wrData == CMD_CHIP);
    stat.sectCmd  = (wrData == CMD_SECT);
    stat.suspCmd  = (wrData == CMD_SUSP);
    stat.winDone  = (winCnt == WIN_LAST);
    stat.ersDone  = (ersCnt == ERS_LAST);
    stat.suspDone = (suspCnt == SUSP_LAST);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      winCnt  <= '0;
      ersCnt  <= '0;
      suspCnt <= '0;
    end else begin
      if (ctl.winClr)       winCnt  <= '0;
      else if (ctl.winInc)  winCnt  <= winCnt + 1'b1;
      if (ctl.ersClr)       ersCnt  <= '0;
      else if (ctl.ersInc)  ersCnt  <= ersCnt + 1'b1;
      if (ctl.suspClr)      suspCnt <= '0;
      else if (ctl.suspInc) suspCnt <= suspCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             eraseMask <= '0;
    else if (ctl.clrMask)  eraseMask <= '0;
    else if (ctl.setAll)   eraseMask <= '1;
    else if (ctl.addSect)  eraseMask <= eraseMask | (NUM_SECT'(1) << sectIdx);
  end

endmodule

// File: rtl/efc_ctrl.sv
module efc_ctrl
  import efc_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    wrStb,
  input  dpStat_t stat,
  output dpCtl_t  ctl,
  output logic    ready,
  output logic    timerDone,
  output logic [1:0] mode
);

  typedef enum logic [3:0] {
    S_IDLE, S_P1, S_P2, S_P3, S_P4, S_P5,
    S_WIN, S_SECT, S_SWAIT, S_SUSP, S_CHIP
  } state_t;

  state_t state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    ctl       = '0;
    unique case (state)
      S_IDLE: if (wrStb && stat.unlkA) nextState = S_P1;
      S_P1:   if (wrStb) nextState = stat.unlkB ? S_P2 : S_IDLE;
      S_P2:   if (wrStb) nextState = stat.setup ? S_P3 : S_IDLE;
      S_P3:   if (wrStb) nextState = stat.unlkA ? S_P4 : S_IDLE;
      S_P4:   if (wrStb) nextState = stat.unlkB ? S_P5 : S_IDLE;
      S_P5: if (wrStb) begin
        if (stat.chipCmd) begin
          nextState  = S_CHIP;
          ctl.setAll = 1'b1;
          ctl.ersClr = 1'b1;
        end else if (stat.sectCmd) begin
          nextState   = S_WIN;
          ctl.addSect = 1'b1;
          ctl.winClr  = 1'b1;
          ctl.ersClr  = 1'b1;
        end else begin
          nextState = S_IDLE;
        end
      end
      S_WIN: begin
        if (wrStb) begin
          if (stat.sectCmd) begin
            ctl.addSect = 1'b1;
            ctl.winClr  = 1'b1;
          end else if (stat.suspCmd) begin
            nextState   = S_SWAIT;
            ctl.suspClr = 1'b1;
          end else begin
            nextState   = S_IDLE;
            ctl.clrMask = 1'b1;
          end
        end else if (stat.winDone) begin
          nextState = S_SECT;
        end else begin
          ctl.winInc = 1'b1;
        end
      end
      S_SECT: begin
        if (stat.ersDone) begin
          nextState   = S_IDLE;
          ctl.clrMask = 1'b1;
        end else begin
          ctl.ersInc = 1'b1;
          if (wrStb && stat.suspCmd) begin
            nextState   = S_SWAIT;
            ctl.suspClr = 1'b1;
          end
        end
      end
      S_SWAIT: begin
        if (stat.suspDone) nextState = S_SUSP;
        else               ctl.suspInc = 1'b1;
      end
      S_SUSP: if (wrStb && stat.sectCmd) nextState = S_SECT;
      S_CHIP: begin
        if (stat.ersDone) begin
          nextState   = S_IDLE;
          ctl.clrMask = 1'b1;
        end else begin
          ctl.ersInc = 1'b1;
        end
      end
      default: nextState = S_IDLE;
    endcase
  end

  always_comb begin
    unique case (state)
      S_WIN:                   mode = MODE_PEND;
      S_SECT, S_SWAIT, S_CHIP: mode = MODE_ERASE;
      S_SUSP:                  mode = MODE_SUSP;
      default:                 mode = MODE_READ;
    endcase
    ready     = !(state inside {S_WIN, S_SECT, S_SWAIT, S_CHIP});
    timerDone = state inside {S_SECT, S_SWAIT, S_SUSP, S_CHIP};
  end

endmodule

// File: rtl/flash_erase_ctl.sv
module flash_erase_ctl
  import efc_pkg::*;
#(
  parameter int SECT_W   = 3,
  parameter int WIN_CYC  = 16,
  parameter int ERS_CYC  = 40,
  parameter int SUSP_CYC = 6,
  localparam int ADDR_W  = SECT_W + 11,
  localparam int NUM_SECT = 1 << SECT_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrStb,
  input  logic [ADDR_W-1:0]   wrAddr,
  input  logic [7:0]          wrData,
  output logic                ready,
  output logic                timerDone,
  output logic [1:0]          mode,
  output logic [NUM_SECT-1:0] eraseMask
);

  dpCtl_t  ctl;
  dpStat_t stat;

  efc_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .wrStb(wrStb), .stat(stat), .ctl(ctl),
    .ready(ready), .timerDone(timerDone), .mode(mode)
  );

  efc_dp #(
    .SECT_W(SECT_W), .WIN_CYC(WIN_CYC), .ERS_CYC(ERS_CYC), .SUSP_CYC(SUSP_CYC)
  ) i_dp (
    .clk(clk), .rstN(rstN), .wrAddr(wrAddr), .wrData(wrData),
    .ctl(ctl), .stat(stat), .eraseMask(eraseMask)
  );

endmodule

// File: rtl/efc_chk.sv
module efc_chk #(
  parameter int NUM_SECT = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic                wrStb,
  input logic [7:0]          wrData,
  input logic                ready,
  input logic                timerDone,
  input logic [1:0]          mode,
  input logic [NUM_SECT-1:0] eraseMask
);

  // R1 R11: read mode never holds queued sectors
  p_read_mask_clear_r1: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'd0) |-> (eraseMask == '0 && ready && !timerDone));

  // R3: pending window is busy with timer still open
  p_pend_busy_r3: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'd1) |-> (!ready && !timerDone && eraseMask != '0));

  // R5: a sector write inside the window keeps it open
  p_win_restart_r5: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'd1 && wrStb && wrData == 8'h30) |=> (mode == 2'd1));

  // R6: another command inside the window drops to read
  p_win_abort_r6: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'd1 && wrStb && wrData != 8'h30 && wrData != 8'hB0)
      |=> (mode == 2'd0 && eraseMask == '0));

  // R8: suspended state is ready with the mask kept
  p_susp_ready_r8: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'd3) |-> (ready && timerDone && eraseMask != '0));

  // R9: only the resume byte leaves suspension
  p_susp_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'd3 && !(wrStb && wrData == 8'h30)) |=> (mode == 2'd3 && $stable(eraseMask)));

  // R2: erasing is always busy with timer expired
  p_erase_busy_r2: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'd2) |-> (!ready && timerDone));

endmodule

bind flash_erase_ctl efc_chk #(.NUM_SECT(NUM_SECT)) i_efc_chk (
  .clk(clk), .rstN(rstN), .wrStb(wrStb), .wrData(wrData), .ready(ready),
  .timerDone(timerDone), .mode(mode), .eraseMask(eraseMask)
);

// File: tb/test_flash_erase_ctl.sv
`timescale 1ns/1ps
module test_flash_erase_ctl;

  localparam int SECT_W = 3;
  localparam int WIN = 16;
  localparam int ERS = 40;
  localparam int SUS = 6;
  localparam int AW = SECT_W + 11;
  localparam int NS = 1 << SECT_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrStb = 1'b0;
  logic [AW-1:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic ready, timerDone;
  logic [1:0] mode;
  logic [NS-1:0] eraseMask;

  int nRun = 0;
  int nFail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  flash_erase_ctl #(.SECT_W(SECT_W), .WIN_CYC(WIN), .ERS_CYC(ERS), .SUSP_CYC(SUS))
    i_flash_erase_ctl (
      .clk(clk), .rstN(rstN), .wrStb(wrStb), .wrAddr(wrAddr), .wrData(wrData),
      .ready(ready), .timerDone(timerDone), .mode(mode), .eraseMask(eraseMask));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chkState(input string tag, input logic [1:0] m, input logic r,
                          input logic t, input logic [NS-1:0] msk);
    chk({tag, " mode"}, 32'(mode), 32'(m));
    chk({tag, " ready"}, 32'(ready), 32'(r));
    chk({tag, " timer"}, 32'(timerDone), 32'(t));
    chk({tag, " mask"}, 32'(eraseMask), 32'(msk));
  endtask

  task automatic wr(input logic [10:0] lo, input logic [SECT_W-1:0] sect, input logic [7:0] d);
    wrAddr = {sect, lo};
    wrData = d;
    wrStb  = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wrStb  = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic prefix();
    wr(11'h555, 0, 8'hAA);
    wr(11'h2AA, 0, 8'h55);
    wr(11'h555, 0, 8'h80);
    wr(11'h555, 0, 8'hAA);
    wr(11'h2AA, 0, 8'h55);
  endtask

  task automatic t_reset();
    chkState("R11 reset", 2'd0, 1'b1, 1'b0, '0);
  endtask

  task automatic t_bad_prefix();
    wr(11'h555, 0, 8'hAA);
    wr(11'h2AA, 0, 8'h55);
    wr(11'h555, 0, 8'h90);
    wr(11'h555, 0, 8'hAA);
    wr(11'h2AA, 0, 8'h55);
    wr(11'h123, 2, 8'h30);
    chkState("R1 bad prefix", 2'd0, 1'b1, 1'b0, '0);
    idle(2);
    chkState("R1 still idle", 2'd0, 1'b1, 1'b0, '0);
  endtask

  task automatic t_chip();
    prefix();
    wr(11'h555, 0, 8'h10);
    chkState("R2 chip start", 2'd2, 1'b0, 1'b1, '1);
    wr(11'h555, 0, 8'hB0);
    wr(11'h123, 1, 8'h30);
    chkState("R7 writes ignored", 2'd2, 1'b0, 1'b1, '1);
    idle(ERS - 3);
    chkState("R2 last erase clk", 2'd2, 1'b0, 1'b1, '1);
    idle(1);
    chkState("R2 chip done", 2'd0, 1'b1, 1'b0, '0);
  endtask

  task automatic t_sector_window();
    prefix();
    wr(11'h123, 2, 8'h30);
    chkState("R3 sector pending", 2'd1, 1'b0, 1'b0, NS'(8'h04));
    idle(5);
    wr(11'h7FF, 5, 8'h30);
    chkState("R5 second sector", 2'd1, 1'b0, 1'b0, NS'(8'h24));
    idle(WIN - 1);
    chkState("R5 window restarted", 2'd1, 1'b0, 1'b0, NS'(8'h24));
    idle(1);
    chkState("R4 window expired", 2'd2, 1'b0, 1'b1, NS'(8'h24));
    idle(ERS - 1);
    chkState("R4 last erase clk", 2'd2, 1'b0, 1'b1, NS'(8'h24));
    idle(1);
    chkState("R4 sector done", 2'd0, 1'b1, 1'b0, '0);
  endtask

  task automatic t_abort();
    prefix();
    wr(11'h000, 1, 8'h30);
    wr(11'h555, 0, 8'hF0);
    chkState("R6 window abort", 2'd0, 1'b1, 1'b0, '0);
  endtask

  task automatic t_suspend();
    prefix();
    wr(11'h010, 3, 8'h30);
    idle(WIN);
    chkState("R4 erasing", 2'd2, 1'b0, 1'b1, NS'(8'h08));
    wr(11'h555, 0, 8'hAA);
    wr(11'h000, 4, 8'h30);
    chkState("R10 ignored", 2'd2, 1'b0, 1'b1, NS'(8'h08));
    idle(7);
    wr(11'h555, 0, 8'hB0);
    chkState("R8 suspending", 2'd2, 1'b0, 1'b1, NS'(8'h08));
    idle(SUS - 1);
    chkState("R8 suspend last wait", 2'd2, 1'b0, 1'b1, NS'(8'h08));
    idle(1);
    chkState("R8 suspended", 2'd3, 1'b1, 1'b1, NS'(8'h08));
    wr(11'h555, 0, 8'hAA);
    wr(11'h555, 0, 8'hB0);
    chkState("R9 ignored while suspended", 2'd3, 1'b1, 1'b1, NS'(8'h08));
    wr(11'h000, 0, 8'h30);
    chkState("R9 resumed", 2'd2, 1'b0, 1'b1, NS'(8'h08));
    idle(ERS - 10 - 1);
    chkState("R9 remaining last clk", 2'd2, 1'b0, 1'b1, NS'(8'h08));
    idle(1);
    chkState("R9 done", 2'd0, 1'b1, 1'b0, '0);
  endtask

  task automatic t_win_suspend();
    prefix();
    wr(11'h000, 6, 8'h30);
    wr(11'h555, 0, 8'hB0);
    chkState("R8 window suspend", 2'd2, 1'b0, 1'b1, NS'(8'h40));
    idle(SUS);
    chkState("R8 window suspended", 2'd3, 1'b1, 1'b1, NS'(8'h40));
    wr(11'h000, 6, 8'h30);
    idle(ERS - 1);
    chkState("R9 full erase", 2'd2, 1'b0, 1'b1, NS'(8'h40));
    idle(1);
    chkState("R9 window resume done", 2'd0, 1'b1, 1'b0, '0);
  endtask

  task automatic t_reset_abort();
    prefix();
    wr(11'h555, 0, 8'h10);
    idle(3);
    rstN = 1'b0;
    #1;
    chkState("R11 reset abort", 2'd0, 1'b1, 1'b0, '0);
    @(negedge clk);
    rstN = 1'b1;
    idle(2);
    chkState("R11 after release", 2'd0, 1'b1, 1'b0, '0);
  endtask

  initial begin
    idle(2);
    rstN = 1'b1;
    idle(1);
    t_reset();
    t_bad_prefix();
    t_chip();
    t_sector_window();
    t_abort();
    t_suspend();
    t_win_suspend();
    t_reset_abort();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nRun++;
      nFail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

endmodule